// File: doc/BRIEF.md
# Two-Bank SDRAM Command Spacing Checker

This block sits beside the command bus of a two-bank synchronous DRAM and watches every command a controller issues. It keeps a small set of countdown timers per bank and a few shared ones. For each command it decides whether the minimum spacing to earlier commands was kept, and whether any bank has been left open beyond the longest allowed time. It produces nothing on the bus itself: its only outputs are a one-cycle violation pulse, a four-bit code naming the broken rule, and the bank concerned.

All timing limits are given in nanoseconds and turned into whole clock cycles by rounding up against a clock-period parameter (10 ns by default, giving activate-to-access 2, activate-to-close 5, row cycle 8, close-to-open 3, bank-to-bank activate 3, mode-set spacing 2 and maximum open time 10000 cycles; the burst length is 4). A command that breaks a rule is still tracked as if it had been carried out, so a single fault does not hide or invent later ones.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After reset the violation output is low and every timer is clear, so any command in the first cycle after reset is reported as legal.
- R2: A read, write, read-with-close or write-with-close to bank b earlier than 2 cycles after an activate of bank b is reported with code 1.
- R3: Closing bank b (close-one, code 6) or closing both banks (close-all, code 7) earlier than 5 cycles after that bank's activate is reported with code 2.
- R4: An activate of bank b earlier than 8 cycles after the previous activate of bank b, or any activate, mode-set, refresh or self-refresh entry earlier than 8 cycles after a refresh or self-refresh exit, or a mode-set, refresh or self-refresh entry earlier than 8 cycles after an activate of either bank, is reported with code 3.
- R5: An activate of bank b, or a mode-set, refresh or self-refresh entry, is reported with code 4 when issued earlier than 3 cycles after a close of that bank (either bank for the non-activate commands), earlier than 6 cycles after a read-with-close, or earlier than 7 cycles after a write-with-close (the last write beat plus 3 cycles plus one more).
- R6: An activate of one bank earlier than 3 cycles after an activate of the other bank is reported with code 5.
- R7: An activate, mode-set, refresh or self-refresh entry earlier than 2 cycles after a mode-set is reported with code 6.
- R8: Data is written on the write cycle and the 3 following cycles; closing that bank before one idle cycle has followed the last beat (earlier than 5 cycles after the write) is reported with code 7.
- R9: Any read or write variant to either bank earlier than 4 cycles after a write or write-with-close (the cycle after the last beat) is reported with code 8.
- R10: A bank that stays open with no close of it for 10000 cycles after its activate is reported once, with code 9 and that bank's index, in the slot of the 10001st cycle after the activate; a close in or before the 10000th cycle prevents the report.
- R11: The verdict for a command appears on the outputs one clock after the command is sampled; when several rules break at once the smallest code wins, command codes beat code 9, bank 0 ages out before bank 1, and for codes 1 to 8 the bank output echoes the bank input.
- R12: A command that breaks a rule still updates the timers exactly as a legal one would.
- R13: Commands are encoded on four bits as 0 idle, 1 activate, 2 read, 3 write, 4 read-with-close, 5 write-with-close, 6 close-one, 7 close-all, 8 refresh, 9 self-refresh entry, 10 self-refresh exit, 11 mode-set; values 12 to 15 are treated as idle and start no timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Command sampled this cycle (encoding in R13) |
| bank_i | input | 1 | Bank addressed by the command |
| viol_o | output | 1 | One-cycle pulse: the previous cycle broke a rule |
| rule_o | output | 4 | Code of the broken rule, 0 when no violation |
| bank_o | output | 1 | Bank concerned by the reported violation |

## Verification
The hardest situation to reach from the ports is the maximum open-time report, since it needs a bank held open for ten thousand quiet cycles and must fire exactly once; the stimulus opens a bank, idles for that whole window and then checks the single report and the silence after it, then repeats with a close placed in the last legal cycle. The other hard corner is several rules breaking in one command, which a directed activate sequence on alternating banks sets up before a long stretch of weighted random commands, all compared each clock against a timestamp model in the bench.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [3:0] {
        CMD_IDLE      = 4'd0,
        CMD_ACT       = 4'd1,
        CMD_RD        = 4'd2,
        CMD_WR        = 4'd3,
        CMD_RD_CLOSE  = 4'd4,
        CMD_WR_CLOSE  = 4'd5,
        CMD_CLOSE     = 4'd6,
        CMD_CLOSE_ALL = 4'd7,
        CMD_REFRESH   = 4'd8,
        CMD_SREF_IN   = 4'd9,
        CMD_SREF_OUT  = 4'd10,
        CMD_MODE      = 4'd11
    } cmd_e;

    localparam logic [3:0] RULE_NONE     = 4'd0;
    localparam logic [3:0] RULE_ACC      = 4'd1;
    localparam logic [3:0] RULE_OPEN_MIN = 4'd2;
    localparam logic [3:0] RULE_ROWCYC   = 4'd3;
    localparam logic [3:0] RULE_CLOSE    = 4'd4;
    localparam logic [3:0] RULE_XBANK    = 4'd5;
    localparam logic [3:0] RULE_MODE     = 4'd6;
    localparam logic [3:0] RULE_WREC     = 4'd7;
    localparam logic [3:0] RULE_WBURST   = 4'd8;
    localparam logic [3:0] RULE_OPEN_MAX = 4'd9;

    function automatic int ns2cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdc_bank_track.sv
module sdc_bank_track
    import sdc_pkg::*;
#(
    parameter int TRCD_C  = 2,
    parameter int TRAS_C  = 5,
    parameter int TRC_C   = 8,
    parameter int TRP_C   = 3,
    parameter int BURST   = 4,
    parameter int AGE_MAX = 10000,
    parameter int CW      = 4,
    parameter int AW      = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic hit,
    output logic rc_busy,
    output logic rp_busy,
    output logic rcd_busy,
    output logic ras_busy,
    output logic wr_busy,
    output logic over_o
);

    localparam logic [CW-1:0] L_RC  = CW'(TRC_C - 1);
    localparam logic [CW-1:0] L_RCD = CW'(TRCD_C - 1);
    localparam logic [CW-1:0] L_RAS = CW'(TRAS_C - 1);
    localparam logic [CW-1:0] L_RP  = CW'(TRP_C - 1);
    localparam logic [CW-1:0] L_RPR = CW'(BURST + TRP_C - 2);
    localparam logic [CW-1:0] L_RPW = CW'(BURST + TRP_C - 1);
    localparam logic [CW-1:0] L_WR  = CW'(BURST);
    localparam logic [AW-1:0] A_FIRE = AW'(AGE_MAX + 1);

    typedef struct packed {
        logic          active;
        logic [AW-1:0] age;
        logic [CW-1:0] rc;
        logic [CW-1:0] rp;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [CW-1:0] wr;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [CW-1:0] up(input logic [CW-1:0] v, input logic [CW-1:0] l);
        return (v > l) ? v : l;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.rc  = dn(st_q.rc);
        st_d.rp  = dn(st_q.rp);
        st_d.rcd = dn(st_q.rcd);
        st_d.ras = dn(st_q.ras);
        st_d.wr  = dn(st_q.wr);
        if (st_q.active && st_q.age <= A_FIRE) begin
            st_d.age = st_q.age + 1'b1;
        end
        case (cmd)
            CMD_ACT: if (hit) begin
                st_d.active = 1'b1;
                st_d.age    = AW'(1);
                st_d.rc     = up(st_d.rc, L_RC);
                st_d.rcd    = up(st_d.rcd, L_RCD);
                st_d.ras    = up(st_d.ras, L_RAS);
            end
            CMD_WR: if (hit) begin
                st_d.wr = up(st_d.wr, L_WR);
            end
            CMD_RD_CLOSE: if (hit) begin
                st_d.active = 1'b0;
                st_d.rp     = up(st_d.rp, L_RPR);
            end
            CMD_WR_CLOSE: if (hit) begin
                st_d.active = 1'b0;
                st_d.rp     = up(st_d.rp, L_RPW);
            end
            CMD_CLOSE: if (hit) begin
                st_d.active = 1'b0;
                st_d.rp     = up(st_d.rp, L_RP);
            end
            CMD_CLOSE_ALL: begin
                st_d.active = 1'b0;
                st_d.rp     = up(st_d.rp, L_RP);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rc_busy  = (st_q.rc  != '0);
    assign rp_busy  = (st_q.rp  != '0);
    assign rcd_busy = (st_q.rcd != '0);
    assign ras_busy = (st_q.ras != '0);
    assign wr_busy  = (st_q.wr  != '0);
    assign over_o   = st_q.active && (st_q.age == A_FIRE);

    // R10: the open-time report is a single pulse per activation
    p_over_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        over_o |=> !over_o);

    // R10: closing both banks stops any pending age-out
    p_close_all_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CLOSE_ALL) |=> !over_o);

    // R4: an activate of this bank blocks the next row cycle
    if (TRC_C > 1) begin : g_rc_chk
        p_act_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_ACT && hit) |=> rc_busy);
    end

    // R8: a write to this bank holds off its close
    p_write_blocks_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR && hit) |=> wr_busy);

endmodule

// File: rtl/sdc_shared_track.sv
module sdc_shared_track
    import sdc_pkg::*;
#(
    parameter int TRC_C  = 8,
    parameter int TMRD_C = 2,
    parameter int TRRD_C = 3,
    parameter int BURST  = 4,
    parameter int CW     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic bank,
    output logic rcg_busy,
    output logic mrd_busy,
    output logic cwl_busy,
    output logic rrd_hit
);

    localparam logic [CW-1:0] L_RC  = CW'(TRC_C - 1);
    localparam logic [CW-1:0] L_MRD = CW'(TMRD_C - 1);
    localparam logic [CW-1:0] L_RRD = CW'(TRRD_C - 1);
    localparam logic [CW-1:0] L_CWL = CW'(BURST - 1);

    typedef struct packed {
        logic [CW-1:0] rcg;
        logic [CW-1:0] mrd;
        logic [CW-1:0] cwl;
        logic [CW-1:0] rrd;
        logic          last;
    } shr_st_t;

    shr_st_t st_d, st_q;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [CW-1:0] up(input logic [CW-1:0] v, input logic [CW-1:0] l);
        return (v > l) ? v : l;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.rcg = dn(st_q.rcg);
        st_d.mrd = dn(st_q.mrd);
        st_d.cwl = dn(st_q.cwl);
        st_d.rrd = dn(st_q.rrd);
        case (cmd)
            CMD_REFRESH, CMD_SREF_OUT: st_d.rcg = up(st_d.rcg, L_RC);
            CMD_MODE:                  st_d.mrd = up(st_d.mrd, L_MRD);
            CMD_WR, CMD_WR_CLOSE:      st_d.cwl = up(st_d.cwl, L_CWL);
            CMD_ACT: begin
                st_d.rrd  = L_RRD;
                st_d.last = bank;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rcg_busy = (st_q.rcg != '0);
    assign mrd_busy = (st_q.mrd != '0);
    assign cwl_busy = (st_q.cwl != '0);
    assign rrd_hit  = (st_q.rrd != '0) && (bank != st_q.last);

    // R7: a mode-set holds off the following commands
    if (TMRD_C > 1) begin : g_mrd_chk
        p_mode_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_MODE) |=> mrd_busy);
    end

    // R9: a write keeps the data bus busy for the next cycle
    if (BURST > 1) begin : g_cwl_chk
        p_write_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_WR || cmd == CMD_WR_CLOSE) |=> cwl_busy);
    end

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdc_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int TRCD_NS     = 20,
    parameter int TRAS_NS     = 50,
    parameter int TRAS_MAX_NS = 100000,
    parameter int TRC_NS      = 80,
    parameter int TRP_NS      = 30,
    parameter int TRRD_NS     = 30,
    parameter int TMRD_NS     = 20,
    parameter int BURST       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] cmd_i,
    input  logic       bank_i,
    output logic       viol_o,
    output logic [3:0] rule_o,
    output logic       bank_o
);

    localparam int NBANK      = 2;
    localparam int TRCD_C     = ns2cyc(TRCD_NS, CLK_NS);
    localparam int TRAS_C     = ns2cyc(TRAS_NS, CLK_NS);
    localparam int TRAS_MAX_C = ns2cyc(TRAS_MAX_NS, CLK_NS);
    localparam int TRC_C      = ns2cyc(TRC_NS, CLK_NS);
    localparam int TRP_C      = ns2cyc(TRP_NS, CLK_NS);
    localparam int TRRD_C     = ns2cyc(TRRD_NS, CLK_NS);
    localparam int TMRD_C     = ns2cyc(TMRD_NS, CLK_NS);
    localparam int CMAX       = maxi(maxi(maxi(TRC_C, TRAS_C), maxi(TRCD_C, TRRD_C)),
                                     maxi(maxi(TMRD_C, BURST + TRP_C), BURST + 1));
    localparam int CW         = $clog2(CMAX + 1);
    localparam int AW         = $clog2(TRAS_MAX_C + 3);

    typedef struct packed {
        logic       viol;
        logic [3:0] rule;
        logic       bank;
    } verdict_t;

    cmd_e            cmd;
    logic [NBANK-1:0] rc_b, rp_b, rcd_b, ras_b, wr_b, ovr_b;
    logic             rcg_busy, mrd_busy, cwl_busy, rrd_hit;
    verdict_t         out_d, out_q;

    assign cmd = cmd_e'(cmd_i);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdc_bank_track #(
            .TRCD_C (TRCD_C),
            .TRAS_C (TRAS_C),
            .TRC_C  (TRC_C),
            .TRP_C  (TRP_C),
            .BURST  (BURST),
            .AGE_MAX(TRAS_MAX_C),
            .CW     (CW),
            .AW     (AW)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .hit     (bank_i == 1'(g)),
            .rc_busy (rc_b[g]),
            .rp_busy (rp_b[g]),
            .rcd_busy(rcd_b[g]),
            .ras_busy(ras_b[g]),
            .wr_busy (wr_b[g]),
            .over_o  (ovr_b[g])
        );
    end

    sdc_shared_track #(
        .TRC_C (TRC_C),
        .TMRD_C(TMRD_C),
        .TRRD_C(TRRD_C),
        .BURST (BURST),
        .CW    (CW)
    ) u_shared (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .bank    (bank_i),
        .rcg_busy(rcg_busy),
        .mrd_busy(mrd_busy),
        .cwl_busy(cwl_busy),
        .rrd_hit (rrd_hit)
    );

    always_comb begin
        logic f_acc, f_omin, f_rc, f_rp, f_xb, f_mode, f_wrec, f_wb;
        f_acc = 1'b0; f_omin = 1'b0; f_rc = 1'b0; f_rp = 1'b0;
        f_xb  = 1'b0; f_mode = 1'b0; f_wrec = 1'b0; f_wb = 1'b0;
        case (cmd)
            CMD_ACT: begin
                f_rc   = rc_b[bank_i] | rcg_busy;
                f_rp   = rp_b[bank_i];
                f_xb   = rrd_hit;
                f_mode = mrd_busy;
            end
            CMD_MODE, CMD_REFRESH, CMD_SREF_IN: begin
                f_rc   = (|rc_b) | rcg_busy;
                f_rp   = |rp_b;
                f_mode = mrd_busy;
            end
            CMD_RD, CMD_WR, CMD_RD_CLOSE, CMD_WR_CLOSE: begin
                f_acc = rcd_b[bank_i];
                f_wb  = cwl_busy;
            end
            CMD_CLOSE: begin
                f_omin = ras_b[bank_i];
                f_wrec = wr_b[bank_i];
            end
            CMD_CLOSE_ALL: begin
                f_omin = |ras_b;
                f_wrec = |wr_b;
            end
            default: ;
        endcase

        out_d = '{viol: 1'b1, rule: RULE_NONE, bank: bank_i};
        if      (f_acc)    out_d.rule = RULE_ACC;
        else if (f_omin)   out_d.rule = RULE_OPEN_MIN;
        else if (f_rc)     out_d.rule = RULE_ROWCYC;
        else if (f_rp)     out_d.rule = RULE_CLOSE;
        else if (f_xb)     out_d.rule = RULE_XBANK;
        else if (f_mode)   out_d.rule = RULE_MODE;
        else if (f_wrec)   out_d.rule = RULE_WREC;
        else if (f_wb)     out_d.rule = RULE_WBURST;
        else if (ovr_b[0]) out_d = '{viol: 1'b1, rule: RULE_OPEN_MAX, bank: 1'b0};
        else if (ovr_b[1]) out_d = '{viol: 1'b1, rule: RULE_OPEN_MAX, bank: 1'b1};
        else               out_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign viol_o = out_q.viol;
    assign rule_o = out_q.rule;
    assign bank_o = out_q.bank;

    // R11: a pulse always carries a code and silence carries none
    p_pulse_has_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o == (rule_o != RULE_NONE));

    // R13: idle and unused codes with no bank ageing out give no pulse
    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == 4'd0 || cmd_i >= 4'd12) && ovr_b == '0) |=> !viol_o);

    // R4: two activates of one bank on consecutive cycles are flagged
    if (TRC_C > 1) begin : g_back_to_back
        p_act_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_ACT && $past(cmd) == CMD_ACT && $past(rst_n)
             && $past(bank_i) == bank_i) |=> viol_o);
    end

endmodule

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;

    localparam int PER    = 10;
    localparam int BURST  = 4;
    localparam int RCD    = (20 + PER - 1) / PER;
    localparam int RAS    = (50 + PER - 1) / PER;
    localparam int RC     = (80 + PER - 1) / PER;
    localparam int RP     = (30 + PER - 1) / PER;
    localparam int RRD    = (30 + PER - 1) / PER;
    localparam int MRD    = (20 + PER - 1) / PER;
    localparam int AGEMAX = (100000 + PER - 1) / PER;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd_i = 4'd0;
    logic       bank_i = 1'b0;
    logic       viol_o;
    logic [3:0] rule_o;
    logic       bank_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // timestamp model state
    int now = 0;
    int act_t[2], rp_ok[2], wr_ok[2];
    bit open[2];
    int rcg_ok = 0, mrd_ok = 0, cwl_ok = 0;
    int last_t = -1000;
    int last_b = 0;
    int exp_code = 0;
    int exp_bank = 0;

    sdram_cmd_checker u_sdram_cmd_checker (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (cmd_i),
        .bank_i(bank_i),
        .viol_o(viol_o),
        .rule_o(rule_o),
        .bank_o(bank_o)
    );

    always #4 clk = ~clk;

    function automatic string tag_of(input int code);
        case (code)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R8";
            8: return "R9";
            9: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic model(input int c, input int b);
        bit is_act, is_ctl, is_rw, is_cl, is_all;
        bit r[1:8];
        is_act = (c == 1);
        is_ctl = (c == 8 || c == 9 || c == 11);
        is_rw  = (c >= 2 && c <= 5);
        is_cl  = (c == 6);
        is_all = (c == 7);
        r[1] = is_rw && now < act_t[b] + RCD;
        r[2] = (is_cl && now < act_t[b] + RAS) ||
               (is_all && (now < act_t[0] + RAS || now < act_t[1] + RAS));
        r[3] = (is_act && (now < act_t[b] + RC || now < rcg_ok)) ||
               (is_ctl && (now < act_t[0] + RC || now < act_t[1] + RC || now < rcg_ok));
        r[4] = (is_act && now < rp_ok[b]) || (is_ctl && (now < rp_ok[0] || now < rp_ok[1]));
        r[5] = is_act && b != last_b && now < last_t + RRD;
        r[6] = (is_act || is_ctl) && now < mrd_ok;
        r[7] = (is_cl && now < wr_ok[b]) || (is_all && (now < wr_ok[0] || now < wr_ok[1]));
        r[8] = is_rw && now < cwl_ok;
        exp_code = 0;
        exp_bank = b;
        for (int k = 8; k >= 1; k--) if (r[k]) exp_code = k;
        if (exp_code == 0) begin
            if (open[1] && now == act_t[1] + AGEMAX + 1) begin exp_code = 9; exp_bank = 1; end
            if (open[0] && now == act_t[0] + AGEMAX + 1) begin exp_code = 9; exp_bank = 0; end
        end
        case (c)
            1: begin act_t[b] = now; open[b] = 1'b1; last_t = now; last_b = b; end
            3: begin cwl_ok = mx(cwl_ok, now + BURST); wr_ok[b] = mx(wr_ok[b], now + BURST + 1); end
            4: begin open[b] = 1'b0; rp_ok[b] = mx(rp_ok[b], now + BURST + RP - 1); end
            5: begin open[b] = 1'b0; cwl_ok = mx(cwl_ok, now + BURST);
                     rp_ok[b] = mx(rp_ok[b], now + BURST + RP); end
            6: begin open[b] = 1'b0; rp_ok[b] = mx(rp_ok[b], now + RP); end
            7: for (int k = 0; k < 2; k++) begin open[k] = 1'b0; rp_ok[k] = mx(rp_ok[k], now + RP); end
            8, 10: rcg_ok = mx(rcg_ok, now + RC);
            11: mrd_ok = mx(mrd_ok, now + MRD);
            default: ;
        endcase
        now++;
    endtask

    // drive one command, advance one clock, compare with the model
    task automatic tick(input int c, input int b);
        cmd_i  = 4'(c);
        bank_i = 1'(b);
        @(posedge clk);
        model(c, b);
        @(negedge clk);
        checks++;
        if (viol_o !== (exp_code != 0) || rule_o !== 4'(exp_code) ||
            (exp_code != 0 && bank_o !== 1'(exp_bank))) begin
            errors++;
            $display("FAIL %s cycle %0d: got viol=%0b rule=%0d bank=%0d, expected viol=%0b rule=%0d bank=%0d",
                     tag_of(exp_code != 0 ? exp_code : int'(rule_o)), now - 1,
                     viol_o, rule_o, bank_o, exp_code != 0, exp_code, exp_bank);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0);
    endtask

    // directed check with a hand-worked expected value
    task automatic expect_out(input int code, input int b, input string tag);
        checks++;
        if (rule_o !== 4'(code) || viol_o !== (code != 0) || (code != 0 && bank_o !== 1'(b))) begin
            errors++;
            $display("FAIL %s: got viol=%0b rule=%0d bank=%0d, expected rule=%0d bank=%0d",
                     tag, viol_o, rule_o, bank_o, code, b);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            act_t[k] = -100000; rp_ok[k] = 0; wr_ok[k] = 0; open[k] = 1'b0;
        end
        // R1: outputs quiet during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (viol_o !== 1'b0 || rule_o !== 4'd0) begin
                errors++;
                $display("FAIL R1: reset viol=%0b rule=%0d, expected 0 0", viol_o, rule_o);
            end
        end
        rst_n = 1'b1;

        // R1: first command after reset is legal
        tick(11, 0); expect_out(0, 0, "R1");
        idle(10);

        // R2: access too soon after activate, then at the limit
        tick(1, 0); tick(2, 0); expect_out(1, 0, "R2");
        tick(2, 0); expect_out(0, 0, "R2");
        idle(10); tick(6, 0); expect_out(0, 0, "R3"); idle(10);

        // R3: close too soon after activate
        tick(1, 1); idle(3); tick(6, 1); expect_out(2, 1, "R3");
        idle(10);

        // R5: activate too soon after a close
        tick(1, 1); idle(7); tick(6, 1); expect_out(0, 1, "R5");
        tick(1, 1); expect_out(4, 1, "R5");
        idle(10); tick(6, 1); idle(10);

        // R5: refresh too soon after read-with-close
        tick(1, 0); idle(5); tick(4, 0); expect_out(0, 0, "R5");
        idle(4); tick(8, 0); expect_out(4, 0, "R5");
        idle(12);

        // R5: activate one cycle early after write-with-close
        tick(1, 1); idle(5); tick(5, 1); expect_out(0, 1, "R5");
        idle(5); tick(1, 1); expect_out(4, 1, "R5");
        idle(12); tick(7, 0); expect_out(0, 0, "R3"); idle(12);

        // R6 and R11: cross-bank activate, then two rules at once
        tick(1, 0); tick(1, 1); expect_out(5, 1, "R6");
        tick(1, 0); expect_out(3, 0, "R11");
        idle(12); tick(7, 0); idle(12);

        // R7 then R4: refresh right after mode-set, activate right after refresh
        tick(11, 0); tick(8, 0); expect_out(6, 0, "R7");
        tick(1, 0); expect_out(3, 0, "R4");
        idle(12);

        // R9 and R8: read during write burst, close before write recovery
        tick(3, 0); expect_out(0, 0, "R9");
        tick(2, 0); expect_out(8, 0, "R9");
        tick(0, 0); tick(6, 0); expect_out(7, 0, "R8");
        idle(12);

        // R12: a flagged activate still restarts the timers
        tick(1, 0); tick(1, 0); expect_out(3, 0, "R12");
        tick(2, 0); expect_out(1, 0, "R12");
        idle(12); tick(7, 0); idle(12);

        // R13: unused code starts no timer
        tick(1, 1); tick(15, 1); expect_out(0, 1, "R13");
        tick(2, 1); expect_out(0, 1, "R13");
        tick(12, 0); expect_out(0, 0, "R13");
        idle(12); tick(7, 0); idle(12);

        // R10: open too long, reported once
        tick(1, 1); idle(AGEMAX); tick(0, 0); expect_out(9, 1, "R10");
        tick(0, 0); expect_out(0, 0, "R10");
        // R10: close in the last legal cycle prevents the report
        tick(1, 0); idle(AGEMAX - 1); tick(6, 0); expect_out(0, 0, "R10");
        tick(0, 0); expect_out(0, 0, "R10");
        tick(7, 0); idle(12);

        // weighted random commands compared against the model each clock
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 31);
            tick(r < 16 ? 0 : r - 16, $urandom_range(0, 1));
        end
        finish_run();
    end

endmodule